// File: doc/BRIEF.md
# Receive/Transmit Line Status and Interrupt Identifier

This block sits beside the receive and transmit queues of a 16550-style serial port and turns their events into two views for software. The first is an eight-bit line status byte: data ready, overrun, the three per-character receive errors, the two transmitter empty indications and a sticky summary of errors still waiting in the receive queue. The second is a four-bit interrupt identification code that names the single highest-priority pending source, together with an interrupt line.

The receive queue reports each assembled character with its error flags, its pops, its occupancy and the error flags of the entry currently at its head. Parity, framing and break status therefore follow the character that carries them rather than the moment it arrived. A pulse on the status-read strobe acknowledges the read-to-clear flags, and a pulse on the identification-read strobe acknowledges a transmitter-empty interrupt that is being reported.

Top module: `line_status_irq`

## Requirements
- R1: Status bit 0 (ready) is 1 exactly while the receive occupancy is non-zero.
- R2: Status bit 1 (overrun) sets in the cycle after a character is assembled while the occupancy equals the queue depth; a status read clears it, and a new overrun in the same cycle as a read wins.
- R3: Status bits 2, 3 and 4 (parity, framing, break) show the flags of the head entry while the queue is non-empty; a status read hides them until the head changes (a pop, or a push into an empty queue).
- R4: Status bit 7 sets in the cycle after an errored character (any of parity, framing or break) is accepted into the queue; a status read clears it only if no errored entry remains after that cycle's push and pop.
- R5: Status bit 5 follows the holding-empty input, and status bit 6 is 1 only when both the holding stage and the shift register are empty.
- R6: Identification bit 0 is 0 when an interrupt is pending and 1 otherwise; bits 3:1 are 011 line status, 010 data available, 110 character timeout, 001 holding empty, 000 modem; with nothing pending the code is 0001.
- R7: Line status outranks data available, which outranks character timeout, which outranks holding empty, which outranks modem.
- R8: Data available is raised when the occupancy is at least 1, 4, 8 or 14 for trigger select 0, 1, 2 or 3.
- R9: The receive enable gates both data available and timeout; separate enables gate the holding-empty and the line-status sources; the modem request is taken as already enabled.
- R10: A holding-empty interrupt is armed by a 0-to-1 change of holding-empty, disarmed when the holding stage fills, and disarmed by an identification read while it is the reported source.
- R11: The interrupt output is the inverse of identification bit 0.
- R12: A timeout pulse while the queue is non-empty arms the timeout source; a pop without a new pulse, or an empty queue, disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_assembled | input | 1 | A received character is complete this cycle |
| rx_new_perr | input | 1 | Parity error of the assembled character |
| rx_new_ferr | input | 1 | Framing error of the assembled character |
| rx_new_brk | input | 1 | Break flag of the assembled character |
| rx_pop | input | 1 | Head entry of the receive queue is read out |
| rx_count | input | $clog2(DEPTH+1) | Receive queue occupancy |
| rx_head_perr | input | 1 | Parity error of the head entry |
| rx_head_ferr | input | 1 | Framing error of the head entry |
| rx_head_brk | input | 1 | Break flag of the head entry |
| char_timeout | input | 1 | Character timeout pulse |
| tx_hold_empty | input | 1 | Transmit holding stage is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| modem_irq | input | 1 | Modem interrupt request |
| en_rx | input | 1 | Enable for data-available and timeout sources |
| en_thre | input | 1 | Enable for the holding-empty source |
| en_line | input | 1 | Enable for the line-status source |
| trig_sel | input | 2 | Receive trigger level select |
| lsr_rd | input | 1 | Status byte read strobe |
| iid_rd | input | 1 | Identification read strobe |
| lsr | output | 8 | Line status byte |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request, active high |

## Verification
The embedded properties watch, cycle by cycle, that an overrun event and an errored push always leave their flags set, that a status read without a head change hides the head errors, that a pop without a fresh pulse drops the timeout source, and that the holding-empty source is armed on its edge, dropped after being reported and read, and never hidden under a lower priority than line status. The value of the whole status byte and code under long interleavings of pushes, pops, reads and enable changes, the summary bit surviving a read while errored entries remain, and the exact trigger thresholds can only be shown by the bench's reference model and its directed fill sequence.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

  typedef enum logic [2:0] {
    SRC_MODEM = 3'b000,
    SRC_THRE  = 3'b001,
    SRC_RDA   = 3'b010,
    SRC_LINE  = 3'b011,
    SRC_CTO   = 3'b110
  } irq_src_e;

  // Number of queued characters that raises data-available.
  function automatic logic [4:0] trig_chars(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_chars = 5'd1;
      2'd1:    trig_chars = 5'd4;
      2'd2:    trig_chars = 5'd8;
      default: trig_chars = 5'd14;
    endcase
  endfunction

  // Identification code: source in 3:1, active-low pending flag in 0.
  function automatic logic [3:0] id_code(input logic pending, input irq_src_e src);
    id_code = {src, ~pending};
  endfunction

endpackage

// File: rtl/lsi_rx_track.sv
module lsi_rx_track #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_assembled,
  input  logic             rx_new_perr,
  input  logic             rx_new_ferr,
  input  logic             rx_new_brk,
  input  logic             rx_pop,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_head_perr,
  input  logic             rx_head_ferr,
  input  logic             rx_head_brk,
  input  logic             char_timeout,
  input  logic             lsr_rd,
  output logic             stat_ready,
  output logic             stat_ovr,
  output logic             stat_perr,
  output logic             stat_ferr,
  output logic             stat_brk,
  output logic             stat_fifo_err,
  output logic             cto_pend
);

  // Named internal events, also used by the assertions.
  logic             q_full, q_empty, push_ok, overrun_evt;
  logic             err_in, err_out, head_change;
  logic             head_ack, sum_q, ovr_q, cto_q;
  logic [CNT_W-1:0] err_cnt, err_cnt_nxt;

  assign q_empty     = (rx_count == '0);
  assign q_full      = (rx_count == CNT_W'(DEPTH));
  assign push_ok     = rx_assembled && !q_full;
  assign overrun_evt = rx_assembled && q_full;
  assign err_in      = push_ok && (rx_new_perr || rx_new_ferr || rx_new_brk);
  assign err_out     = rx_pop && !q_empty && (rx_head_perr || rx_head_ferr || rx_head_brk);
  assign head_change = (rx_pop && !q_empty) || (push_ok && q_empty);
  assign err_cnt_nxt = err_cnt + CNT_W'(err_in) - CNT_W'(err_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q    <= 1'b0;
      head_ack <= 1'b0;
      sum_q    <= 1'b0;
      cto_q    <= 1'b0;
      err_cnt  <= '0;
    end else begin
      err_cnt <= err_cnt_nxt;
      if (overrun_evt)      ovr_q <= 1'b1;
      else if (lsr_rd)      ovr_q <= 1'b0;
      if (head_change)      head_ack <= 1'b0;
      else if (lsr_rd)      head_ack <= 1'b1;
      if (err_in)                              sum_q <= 1'b1;
      else if (lsr_rd && err_cnt_nxt == '0)    sum_q <= 1'b0;
      if (char_timeout && !q_empty)            cto_q <= 1'b1;
      else if (rx_pop || q_empty)              cto_q <= 1'b0;
    end
  end

  assign stat_ready    = !q_empty;
  assign stat_ovr      = ovr_q;
  assign stat_perr     = !q_empty && !head_ack && rx_head_perr;
  assign stat_ferr     = !q_empty && !head_ack && rx_head_ferr;
  assign stat_brk      = !q_empty && !head_ack && rx_head_brk;
  assign stat_fifo_err = sum_q;
  assign cto_pend      = cto_q;

  assert_ovr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> stat_ovr);

  assert_head_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !head_change) |=> !(stat_perr || stat_ferr || stat_brk));

  assert_sum_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> stat_fifo_err);

  assert_cto_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !char_timeout) |=> !cto_pend);

endmodule

// File: rtl/lsi_irq_prio.sv
module lsi_irq_prio
  import lsi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_rx,
  input  logic             en_thre,
  input  logic             en_line,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cto_pend,
  input  logic             line_err,
  input  logic             tx_hold_empty,
  input  logic             modem_irq,
  input  logic             iid_rd,
  output logic [3:0]       iid
);

  logic     thre_prev, thre_pend, thre_rise, thre_ack;
  logic     line_req, rda_req, cto_req, thre_req, modem_req;
  logic     pending;
  irq_src_e src;

  assign thre_rise = tx_hold_empty && !thre_prev;
  assign line_req  = en_line && line_err;
  assign rda_req   = en_rx && (32'(rx_count) >= 32'(trig_chars(trig_sel)));
  assign cto_req   = en_rx && cto_pend;
  assign thre_req  = en_thre && thre_pend && tx_hold_empty;
  assign modem_req = modem_irq;

  always_comb begin
    pending = 1'b1;
    src     = SRC_MODEM;
    if (line_req)       src = SRC_LINE;
    else if (rda_req)   src = SRC_RDA;
    else if (cto_req)   src = SRC_CTO;
    else if (thre_req)  src = SRC_THRE;
    else if (modem_req) src = SRC_MODEM;
    else                pending = 1'b0;
  end

  assign iid      = id_code(pending, src);
  assign thre_ack = iid_rd && pending && (src == SRC_THRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_prev <= 1'b1;
      thre_pend <= 1'b0;
    end else begin
      thre_prev <= tx_hold_empty;
      if (thre_rise)                        thre_pend <= 1'b1;
      else if (!tx_hold_empty || thre_ack)  thre_pend <= 1'b0;
    end
  end

  assert_line_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> (iid == 4'b0110));

  assert_thre_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thre_rise |=> thre_pend);

  assert_thre_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_ack && !thre_rise) |=> !thre_pend);

endmodule

// File: rtl/line_status_irq.sv
module line_status_irq #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_assembled,
  input  logic             rx_new_perr,
  input  logic             rx_new_ferr,
  input  logic             rx_new_brk,
  input  logic             rx_pop,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_head_perr,
  input  logic             rx_head_ferr,
  input  logic             rx_head_brk,
  input  logic             char_timeout,
  input  logic             tx_hold_empty,
  input  logic             tx_shift_empty,
  input  logic             modem_irq,
  input  logic             en_rx,
  input  logic             en_thre,
  input  logic             en_line,
  input  logic [1:0]       trig_sel,
  input  logic             lsr_rd,
  input  logic             iid_rd,
  output logic [7:0]       lsr,
  output logic [3:0]       iid,
  output logic             irq
);

  logic s_ready, s_ovr, s_perr, s_ferr, s_brk, s_sum, s_cto, line_err;

  lsi_rx_track #(.DEPTH(DEPTH)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_assembled (rx_assembled),
    .rx_new_perr  (rx_new_perr),
    .rx_new_ferr  (rx_new_ferr),
    .rx_new_brk   (rx_new_brk),
    .rx_pop       (rx_pop),
    .rx_count     (rx_count),
    .rx_head_perr (rx_head_perr),
    .rx_head_ferr (rx_head_ferr),
    .rx_head_brk  (rx_head_brk),
    .char_timeout (char_timeout),
    .lsr_rd       (lsr_rd),
    .stat_ready   (s_ready),
    .stat_ovr     (s_ovr),
    .stat_perr    (s_perr),
    .stat_ferr    (s_ferr),
    .stat_brk     (s_brk),
    .stat_fifo_err(s_sum),
    .cto_pend     (s_cto)
  );

  assign line_err = s_ovr || s_perr || s_ferr || s_brk;

  lsi_irq_prio #(.DEPTH(DEPTH)) u_prio (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_rx        (en_rx),
    .en_thre      (en_thre),
    .en_line      (en_line),
    .trig_sel     (trig_sel),
    .rx_count     (rx_count),
    .cto_pend     (s_cto),
    .line_err     (line_err),
    .tx_hold_empty(tx_hold_empty),
    .modem_irq    (modem_irq),
    .iid_rd       (iid_rd),
    .iid          (iid)
  );

  assign lsr = {s_sum, tx_hold_empty && tx_shift_empty, tx_hold_empty,
                s_brk, s_ferr, s_perr, s_ovr, s_ready};
  assign irq = ~iid[0];

endmodule

// File: tb/line_status_irq_test.sv
`timescale 1ns/1ps
module line_status_irq_test;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic rx_assembled = 0, rx_new_perr = 0, rx_new_ferr = 0, rx_new_brk = 0;
  logic rx_pop = 0, char_timeout = 0, tx_hold_empty = 1, tx_shift_empty = 1;
  logic modem_irq = 0, en_rx = 0, en_thre = 0, en_line = 0;
  logic [1:0] trig_sel = 0;
  logic lsr_rd = 0, iid_rd = 0;
  logic [CW-1:0] rx_count;
  logic rx_head_perr, rx_head_ferr, rx_head_brk;
  logic [7:0] lsr;
  logic [3:0] iid;
  logic irq;

  // Bench-side queue model and status model
  logic [2:0] fq [DEPTH];
  int hd = 0, bcnt = 0, ecnt = 0;
  logic m_ovr = 0, m_ack = 0, m_sum = 0, m_cto = 0, m_prev = 1, m_pend = 0;
  int checks = 0, fails = 0;
  logic done = 0;

  assign rx_count     = CW'(bcnt);
  assign rx_head_perr = (bcnt > 0) ? fq[hd][0] : 1'b0;
  assign rx_head_ferr = (bcnt > 0) ? fq[hd][1] : 1'b0;
  assign rx_head_brk  = (bcnt > 0) ? fq[hd][2] : 1'b0;

  line_status_irq #(.DEPTH(DEPTH)) uut (.*);

  function automatic int trig_of(input logic [1:0] s);
    return (s == 2'd3) ? 14 : ((s == 2'd0) ? 1 : (4 << (s - 1)));
  endfunction

  function automatic logic head_vis_err();
    return (bcnt > 0) && !m_ack && (fq[hd] != 3'b000);
  endfunction

  function automatic logic [3:0] exp_iid();
    if (en_line && (m_ovr || head_vis_err())) return 4'b0110;
    if (en_rx && bcnt >= trig_of(trig_sel))   return 4'b0100;
    if (en_rx && m_cto)                       return 4'b1100;
    if (en_thre && m_pend && tx_hold_empty)   return 4'b0010;
    if (modem_irq)                            return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] exp_lsr();
    logic [2:0] h;
    h = ((bcnt > 0) && !m_ack) ? fq[hd] : 3'b000;
    return {m_sum, tx_hold_empty & tx_shift_empty, tx_hold_empty,
            h[2], h[1], h[0], m_ovr, logic'(bcnt > 0)};
  endfunction

  logic pok, hchg, herr, nerr, thre_ack;
  int ec_n;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd <= 0; bcnt <= 0; ecnt <= 0;
      m_ovr <= 0; m_ack <= 0; m_sum <= 0; m_cto <= 0; m_prev <= 1; m_pend <= 0;
    end else begin
      pok  = rx_assembled && (bcnt != DEPTH);
      nerr = rx_new_perr || rx_new_ferr || rx_new_brk;
      herr = rx_pop && (bcnt > 0) && (fq[hd] != 3'b000);
      hchg = (rx_pop && bcnt > 0) || (pok && bcnt == 0);
      ec_n = ecnt + ((pok && nerr) ? 1 : 0) - (herr ? 1 : 0);
      thre_ack = iid_rd && (exp_iid() == 4'b0010);
      if (pok) fq[(hd + bcnt) % DEPTH] <= {rx_new_brk, rx_new_ferr, rx_new_perr};
      if (rx_pop && bcnt > 0) hd <= (hd + 1) % DEPTH;
      bcnt <= bcnt + (pok ? 1 : 0) - ((rx_pop && bcnt > 0) ? 1 : 0);
      ecnt <= ec_n;
      if (rx_assembled && bcnt == DEPTH) m_ovr <= 1; else if (lsr_rd) m_ovr <= 0;
      if (hchg) m_ack <= 0; else if (lsr_rd) m_ack <= 1;
      if (pok && nerr) m_sum <= 1; else if (lsr_rd && ec_n == 0) m_sum <= 0;
      if (char_timeout && bcnt > 0) m_cto <= 1; else if (rx_pop || bcnt == 0) m_cto <= 0;
      m_prev <= tx_hold_empty;
      if (tx_hold_empty && !m_prev) m_pend <= 1;
      else if (!tx_hold_empty || thre_ack) m_pend <= 0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] el;
    logic [3:0] ei;
    el = exp_lsr();
    ei = exp_iid();
    chk("R1 ready", {7'd0, lsr[0]}, {7'd0, el[0]});
    chk("R2 overrun", {7'd0, lsr[1]}, {7'd0, el[1]});
    chk("R3 head errors", {5'd0, lsr[4:2]}, {5'd0, el[4:2]});
    chk("R4 fifo error", {7'd0, lsr[7]}, {7'd0, el[7]});
    chk("R5 tx empty", {6'd0, lsr[6:5]}, {6'd0, el[6:5]});
    chk("R6 R7 R8 R9 R10 R12 id code", {4'd0, iid}, {4'd0, ei});
    chk("R11 irq", {7'd0, irq}, {7'd0, ~ei[0]});
  endtask

  task automatic rand_cycle(input int pop_pct, input int asm_pct);
    @(negedge clk);
    check_all();
    rx_assembled = ($urandom % 100) < asm_pct;
    rx_new_perr  = ($urandom % 8) == 0;
    rx_new_ferr  = ($urandom % 8) == 0;
    rx_new_brk   = ($urandom % 12) == 0;
    rx_pop       = (bcnt > 0) && (($urandom % 100) < pop_pct);
    char_timeout = ($urandom % 16) == 0;
    if (($urandom % 8) == 0) tx_hold_empty = ~tx_hold_empty;
    if (($urandom % 8) == 0) tx_shift_empty = ~tx_shift_empty;
    if (($urandom % 32) == 0) modem_irq = ~modem_irq;
    lsr_rd = ($urandom % 6) == 0;
    iid_rd = ($urandom % 4) == 0;
  endtask

  task automatic quiet();
    rx_assembled = 0; rx_new_perr = 0; rx_new_ferr = 0; rx_new_brk = 0;
    rx_pop = 0; char_timeout = 0; lsr_rd = 0; iid_rd = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // Reset state: empty queue, both tx stages empty
    chk("R1 R2 R3 R4 R5 reset status", lsr, 8'h60);
    chk("R6 reset id", {4'd0, iid}, 8'h01);
    chk("R11 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    for (int ph = 0; ph < 12; ph++) begin
      en_rx    = $urandom % 2;
      en_thre  = $urandom % 2;
      en_line  = $urandom % 2;
      trig_sel = 2'($urandom % 4);
      for (int c = 0; c < 300; c++)
        rand_cycle((ph % 3 == 0) ? 3 : 25, (ph % 3 == 1) ? 15 : 40);
    end
    // Directed trigger sweep (R8): drain, then fill error-free
    @(negedge clk);
    quiet();
    modem_irq = 0; en_thre = 0; en_line = 0; en_rx = 1; trig_sel = 2'd3;
    for (int k = 0; k < 40 && bcnt > 0; k++) begin
      rx_pop = 1;
      @(negedge clk);
      check_all();
    end
    rx_pop = 0;
    for (int n = 1; n <= 14; n++) begin
      rx_assembled = 1;
      @(negedge clk);
      rx_assembled = 0;
      @(negedge clk);
      check_all();
      if (n == 13) chk("R8 below trigger 14", {4'd0, iid}, 8'h01);
      if (n == 14) chk("R8 at trigger 14", {4'd0, iid}, 8'h04);
    end
    trig_sel = 2'd2;
    @(negedge clk);
    chk("R8 select 2 over 8", {4'd0, iid}, 8'h04);
    en_rx = 0;
    @(negedge clk);
    chk("R9 receive enable off", {4'd0, iid}, 8'h01);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule